// File: doc/BRIEF.md
# Redundant Memory Access Filter

This block sits between a requester and a synchronous single-port RAM. It passes each request through to the memory unless the access could not change anything a consumer sees. When an access is dropped, the memory enable stays low for that cycle and the RAM spends no dynamic energy. Three kinds of access are dropped. The first is a read whose result is marked as unused downstream. The second is an observed read of the same address as the last performed read, with no write request in between. The third is a write whose address and data both match the last performed write, with no performed read in between.

Read data comes back one cycle after the request in every case. After a performed read, the data comes straight from the memory and a copy is kept in a hold register. After a reused read, the data comes from that hold register. A small response machine chooses between the two sources. Its states are `S_IDLE` (no response this cycle), `S_MEM` (respond with the memory output and capture it) and `S_HELD` (respond with the held copy). Each cycle the machine moves to a new state based only on the current request. A performed observed read moves it to `S_MEM`. A reused read moves it to `S_HELD`. Anything else (idle, a write, a dropped read or a conflict) moves it to `S_IDLE`. These transitions are the same whatever the present state is.

Two counters report how many reads and how many writes were dropped. A request that asks for a read and a write in the same cycle is not allowed. In that case the block raises a conflict flag, handles the write and discards the read.

Top module: `mem_access_filter`

## Requirements
- R1: A read request (`req_rd`=1, `req_wr`=0) with `req_observed`=0 leaves `mem_ce` low in that cycle and produces no `rsp_valid` in the next cycle.
- R2: An observed read of the same address as the last performed read leaves `mem_ce` low when no write request came in between. One cycle later `rsp_valid` is high and `rsp_rdata` equals the data returned by that performed read.
- R3: Any write request, performed or dropped, invalidates the read history, so the next observed read is performed even when its address matches.
- R4: A write whose address and data both equal those of the last performed write leaves `mem_ce` low. A write that differs in address or data is performed with `mem_ce`=1 and `mem_we`=1.
- R5: A performed read invalidates the write history, so a write after it is performed even if it repeats the previous write exactly.
- R6: After reset both histories are invalid, so the first read and the first write are performed; `rsp_valid`, `mem_ce` and both counters are 0 during reset.
- R7: A performed observed read drives `mem_ce`=1 and `mem_we`=0 in the request cycle. In the next cycle it gives `rsp_valid`=1 with `rsp_rdata` equal to `mem_rdata`.
- R8: When `req_rd` and `req_wr` are both high, `conflict_err` is 1 and the request is handled exactly as a write alone. The read is never sent to the memory and gives no response.
- R9: `rd_saved_cnt` rises by one for each read dropped under R1 or R2. `wr_saved_cnt` rises by one for each write dropped under R4. Neither counter changes otherwise.
- R10: A read dropped under R1 does not change the read history or the held data. An observed read to the last performed address that follows it is still reused.
- R11: Whenever `mem_ce` is 1, `mem_addr` equals `req_addr`. On a write, `mem_wdata` also equals `req_wdata`. `mem_we` is never 1 while `mem_ce` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_rd | input | 1 | Read request this cycle |
| req_wr | input | 1 | Write request this cycle |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_observed | input | 1 | Read result will be consumed downstream |
| rsp_valid | output | 1 | Read response valid (one cycle after an observed read) |
| rsp_rdata | output | DATA_W | Read response data |
| conflict_err | output | 1 | Read and write requested together |
| mem_ce | output | 1 | Memory chip enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after an enabled read |
| rd_saved_cnt | output | CNT_W | Count of dropped reads |
| wr_saved_cnt | output | CNT_W | Count of dropped writes |

## Verification
The assertions assume a memory that updates `mem_rdata` only in the cycle after an enabled read. They also assume a memory that keeps its contents unless `mem_we` is asserted, because R2 and R4 are only correct for such a memory. The bench meets this with a behavioural array that registers its read output on enabled reads only. The assertions also assume the request inputs are quiet during reset. The stimulus holds every request low while `rst_n` is low and changes inputs only on the falling clock edge. One deliberate conflict cycle exercises R8.

// File: rtl/maf_pkg.sv
package maf_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MEM,
        S_HELD
    } rsp_state_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_PERFORM,
        RD_REUSE,
        RD_DROP
    } rd_act_e;

endpackage

// File: rtl/maf_decide.sv
module maf_decide
    import maf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              req_observed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rd_hist_v,
    input  logic [ADDR_W-1:0] rd_hist_addr,
    input  logic              wr_hist_v,
    input  logic [ADDR_W-1:0] wr_hist_addr,
    input  logic [DATA_W-1:0] wr_hist_data,
    output rd_act_e           rd_act,
    output logic              wr_perform,
    output logic              wr_dup,
    output logic              conflict
);

    logic rd_only;
    logic addr_hit_rd;
    logic same_write;

    assign conflict    = req_rd & req_wr;
    assign rd_only     = req_rd & ~req_wr;
    assign addr_hit_rd = rd_hist_v && (req_addr == rd_hist_addr);
    assign same_write  = wr_hist_v && (req_addr == wr_hist_addr) && (req_wdata == wr_hist_data);

    assign wr_dup      = req_wr & same_write;
    assign wr_perform  = req_wr & ~same_write;

    always_comb begin
        if (!rd_only)           rd_act = RD_NONE;
        else if (!req_observed) rd_act = RD_DROP;
        else if (addr_hit_rd)   rd_act = RD_REUSE;
        else                    rd_act = RD_PERFORM;
    end

endmodule

// File: rtl/maf_history.sv
module maf_history
    import maf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_act_e           rd_act,
    input  logic              wr_any,
    input  logic              wr_perform,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_hist_v,
    output logic [ADDR_W-1:0] rd_hist_addr,
    output logic              wr_hist_v,
    output logic [ADDR_W-1:0] wr_hist_addr,
    output logic [DATA_W-1:0] wr_hist_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hist_v    <= 1'b0;
            rd_hist_addr <= '0;
            wr_hist_v    <= 1'b0;
            wr_hist_addr <= '0;
            wr_hist_data <= '0;
        end else if (wr_any) begin
            rd_hist_v <= 1'b0;
            if (wr_perform) begin
                wr_hist_v    <= 1'b1;
                wr_hist_addr <= req_addr;
                wr_hist_data <= req_wdata;
            end
        end else if (rd_act == RD_PERFORM) begin
            rd_hist_v    <= 1'b1;
            rd_hist_addr <= req_addr;
            wr_hist_v    <= 1'b0;
        end
    end

    assert_write_clears_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> !rd_hist_v);

    assert_read_clears_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act == RD_PERFORM) |=> (!wr_hist_v && rd_hist_v));

    assert_drop_keeps_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act == RD_DROP) |=> ($stable(rd_hist_v) && $stable(rd_hist_addr)));

endmodule

// File: rtl/maf_resp.sv
module maf_resp
    import maf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_act_e           rd_act,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        unique case (rd_act)
            RD_PERFORM: state_d = S_MEM;
            RD_REUSE:   state_d = S_HELD;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_MEM) hold_q <= mem_rdata;
        end
    end

    always_comb begin
        unique case (state_q)
            S_MEM: begin
                rsp_valid = 1'b1;
                rsp_rdata = mem_rdata;
            end
            S_HELD: begin
                rsp_valid = 1'b1;
                rsp_rdata = hold_q;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_rdata = hold_q;
            end
        endcase
    end

    assert_drop_keeps_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_MEM) |=> $stable(hold_q));

endmodule

// File: rtl/maf_counter.sv
module maf_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));

endmodule

// File: rtl/mem_access_filter.sv
module mem_access_filter
    import maf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_observed,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              conflict_err,
    output logic              mem_ce,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  rd_saved_cnt,
    output logic [CNT_W-1:0]  wr_saved_cnt
);

    localparam int N_CNT = 2;

    rd_act_e           rd_act;
    logic              wr_perform;
    logic              wr_dup;
    logic              rd_hist_v;
    logic [ADDR_W-1:0] rd_hist_addr;
    logic              wr_hist_v;
    logic [ADDR_W-1:0] wr_hist_addr;
    logic [DATA_W-1:0] wr_hist_data;
    logic [N_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cnt_val [N_CNT];

    maf_decide #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decide (
        .req_rd       (req_rd),
        .req_wr       (req_wr),
        .req_observed (req_observed),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rd_hist_v    (rd_hist_v),
        .rd_hist_addr (rd_hist_addr),
        .wr_hist_v    (wr_hist_v),
        .wr_hist_addr (wr_hist_addr),
        .wr_hist_data (wr_hist_data),
        .rd_act       (rd_act),
        .wr_perform   (wr_perform),
        .wr_dup       (wr_dup),
        .conflict     (conflict_err)
    );

    maf_history #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_history (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_act       (rd_act),
        .wr_any       (req_wr),
        .wr_perform   (wr_perform),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rd_hist_v    (rd_hist_v),
        .rd_hist_addr (rd_hist_addr),
        .wr_hist_v    (wr_hist_v),
        .wr_hist_addr (wr_hist_addr),
        .wr_hist_data (wr_hist_data)
    );

    maf_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_act    (rd_act),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign cnt_inc[0] = (rd_act == RD_DROP) || (rd_act == RD_REUSE);
    assign cnt_inc[1] = wr_dup;

    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
        maf_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[gi]),
            .count (cnt_val[gi])
        );
    end

    assign rd_saved_cnt = cnt_val[0];
    assign wr_saved_cnt = cnt_val[1];

    assign mem_ce    = wr_perform || (rd_act == RD_PERFORM);
    assign mem_we    = wr_perform;
    assign mem_addr  = req_addr;
    assign mem_wdata = req_wdata;

    assert_unobserved_no_ce_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && !req_wr && !req_observed) |-> !mem_ce);

    assert_unobserved_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && !req_wr && !req_observed) |=> !rsp_valid);

    assert_repeat_read_no_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && !req_wr && req_observed && $past(mem_ce && !mem_we) && req_addr == $past(req_addr))
        |-> !mem_ce);

    assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce && !mem_we) |=> (rsp_valid && rsp_rdata == mem_rdata));

    assert_conflict_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_err |-> (!mem_ce || mem_we));

    assert_conflict_no_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_err |=> !rsp_valid);

    assert_we_needs_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_ce);

endmodule

// File: tb/tb_mem_access_filter.sv
module tb_mem_access_filter;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_rd = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_observed = 1'b0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          conflict_err;
    logic          mem_ce;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic [CW-1:0] rd_saved_cnt;
    logic [CW-1:0] wr_saved_cnt;

    int tests = 0;
    int fails = 0;
    bit running = 1'b0;

    logic [DW-1:0] ram [DEPTH];
    logic [DW-1:0] ram_q = '0;
    logic [DW-1:0] model_mem [DEPTH];
    logic [DW-1:0] exp_q [$];

    bit            m_rv;
    logic [AW-1:0] m_ra;
    logic [DW-1:0] m_hold;
    bit            m_wv;
    logic [AW-1:0] m_wa;
    logic [DW-1:0] m_wd;
    int            exp_rs = 0;
    int            exp_ws = 0;

    always #10 clk = ~clk;

    mem_access_filter #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_rd       (req_rd),
        .req_wr       (req_wr),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_observed (req_observed),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .conflict_err (conflict_err),
        .mem_ce       (mem_ce),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .rd_saved_cnt (rd_saved_cnt),
        .wr_saved_cnt (wr_saved_cnt)
    );

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ram[i]       = DW'(i * 37 + 5);
            model_mem[i] = DW'(i * 37 + 5);
        end
    end

    always @(posedge clk) begin
        if (mem_ce) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        ram_q <= ram[mem_addr];
        end
    end
    assign mem_rdata = ram_q;

    task automatic check(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_rv = 0; m_wv = 0; m_ra = '0; m_wa = '0; m_wd = '0; m_hold = '0;
        exp_rs = 0; exp_ws = 0;
    endtask

    // driver: applies one request, checks the memory side, pushes expected responses
    task automatic do_op(bit rd, bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit obs, string req);
        bit ece, ewe;
        @(negedge clk);
        req_rd = rd; req_wr = wr; req_addr = a; req_wdata = d; req_observed = obs;
        ece = 0; ewe = 0;
        if (wr) begin
            if (m_wv && a == m_wa && d == m_wd) begin
                exp_ws++;
            end else begin
                ece = 1; ewe = 1;
                model_mem[a] = d;
                m_wv = 1; m_wa = a; m_wd = d;
            end
            m_rv = 0;
        end else if (rd) begin
            if (!obs) begin
                exp_rs++;
            end else if (m_rv && a == m_ra) begin
                exp_rs++;
                exp_q.push_back(m_hold);
            end else begin
                ece = 1;
                m_hold = model_mem[a];
                exp_q.push_back(m_hold);
                m_rv = 1; m_ra = a; m_wv = 0;
            end
        end
        #1;
        check({req, " mem_ce"}, mem_ce, ece);
        check({req, " mem_we"}, mem_we, ewe);
        check({req, " conflict_err"}, conflict_err, rd && wr);
        if (ece) begin
            check("R11 mem_addr", mem_addr, a);
            if (ewe) check("R11 mem_wdata", mem_wdata, d);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) do_op(0, 0, '0, '0, 0, "idle");
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (running && rst_n && rsp_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected response: actual %0h expected none", rsp_rdata);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (rsp_rdata != e) begin
                    fails++;
                    $display("FAIL R2/R7 rsp_rdata: actual %0h expected %0h", rsp_rdata, e);
                end
            end
        end
    end

    task automatic check_counts(string req);
        check({req, " rd_saved_cnt"}, rd_saved_cnt, exp_rs);
        check({req, " wr_saved_cnt"}, wr_saved_cnt, exp_ws);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check("R6 reset rsp_valid", rsp_valid, 0);
        check("R6 reset mem_ce", mem_ce, 0);
        check("R6 reset counters", rd_saved_cnt + wr_saved_cnt, 0);
        rst_n = 1'b1;
        running = 1'b1;

        do_op(1, 0, 8'd5, '0, 1, "R6 first read");
        do_op(1, 0, 8'd5, '0, 1, "R2 repeat read");
        do_op(1, 0, 8'd5, '0, 1, "R2 repeat read 2");
        do_op(1, 0, 8'd5, '0, 0, "R1 unobserved same");
        do_op(1, 0, 8'd9, '0, 0, "R1 unobserved other");
        do_op(1, 0, 8'd5, '0, 1, "R10 reuse after drop");
        do_op(1, 0, 8'd9, '0, 1, "R7 new address");
        check_counts("R9 after reads");

        do_op(0, 1, 8'd5, 16'hAAAA, 0, "R6 first write");
        do_op(1, 0, 8'd5, '0, 1, "R3 read after write");
        do_op(1, 0, 8'd5, '0, 1, "R2 reuse written");
        do_op(0, 1, 8'd7, 16'h1234, 0, "R4 write new");
        do_op(0, 1, 8'd7, 16'h1234, 0, "R4 write dup");
        do_op(0, 1, 8'd7, 16'h1235, 0, "R4 data differs");
        do_op(0, 1, 8'd8, 16'h1235, 0, "R4 addr differs");
        do_op(0, 1, 8'd8, 16'h1235, 0, "R4 write dup 2");
        do_op(1, 0, 8'd8, '0, 1, "R5 read between");
        do_op(0, 1, 8'd8, 16'h1235, 0, "R5 write repeats");
        do_op(0, 1, 8'd8, 16'h1235, 0, "R3 dup write");
        do_op(1, 0, 8'd8, '0, 1, "R3 read after dup write");
        check_counts("R9 after writes");

        do_op(1, 1, 8'd10, 16'h0055, 1, "R8 conflict");
        do_op(1, 0, 8'd10, '0, 1, "R8 read back");
        do_op(1, 0, 8'd7, '0, 1, "R7 back to back");
        do_op(1, 0, 8'd8, '0, 1, "R7 back to back 2");
        do_op(1, 0, 8'd7, '0, 1, "R7 alternate");
        idle(3);
        check_counts("R9 after conflict");
        check("R7 all responses seen", exp_q.size(), 0);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 counters cleared", rd_saved_cnt + wr_saved_cnt, 0);
        model_reset();
        rst_n = 1'b1;
        do_op(1, 0, 8'd7, '0, 1, "R6 read after reset");
        do_op(0, 1, 8'd8, 16'h1235, 0, "R6 write after reset");
        idle(2);
        check_counts("R9 after reset");
        check("R7 queue drained", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule